// File: doc/BRIEF.md
# Bias-Preloaded Integer Matrix-Vector Multiply-Accumulate Array

This block computes one matrix-vector product with bias on small signed integers. It holds a ROWS-by-COLS grid of multipliers and ROWS accumulators. An operation takes two cycles. In the first cycle every accumulator takes its bias as its starting value. In the second cycle each multiplier forms the product of its weight and the activation for its column, and each accumulator adds the sum of its row of products in one step.

A client sets `start` and puts the biases on their bus. It then puts the weight matrix and the activation vector on their buses for the following cycle, and reads the results when `done` pulses. The accumulator width is 2*BW + clog2(COLS) + 1 bits, so no legal operand combination can overflow. The results stay on the output until another operation begins.

Top module: `mv_mac_array`

## Requirements
- R1: While reset is asserted and after it is released, every result lane reads zero and `done` and `busy` are low.
- R2: A `start` sampled while idle raises `busy` for the next cycle. In that cycle every result lane n holds bias n, taken from `biases[n*BIAS_W +: BIAS_W]` and sign-extended to ACC_W bits. A `start` in the cycle in which `done` is high is accepted in the same way.
- R3: At the clock edge that ends the busy cycle, lane n becomes bias n plus the sum over m of the signed product W[n][m]*x[m]. W[n][m] is `weights[(n*COLS+m)*BW +: BW]`, x[m] is `acts[m*BW +: BW]`, and lane n is `result[n*ACC_W +: ACC_W]`, all in two's complement.
- R4: Weight and activation values present at the edge that samples `start` have no effect on the result. Only the values present at the following edge are used.
- R5: `done` is high for exactly one cycle, the first cycle in which the final results are visible, and `busy` is low in that cycle.
- R6: While idle with `start` low, the result bus does not change, whatever the other inputs do.
- R7: A `start` sampled while `busy` is high is ignored. The block returns to idle after the current operation and no second operation begins.
- R8: Operands at their most negative and most positive values, combined with extreme biases, give exact results without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| weights | input | ROWS*COLS*BW | Weight matrix, row-major |
| acts | input | COLS*BW | Activation vector |
| biases | input | ROWS*BIAS_W | One bias per row |
| busy | output | 1 | High during the multiply-accumulate cycle |
| done | output | 1 | One-cycle pulse when results are valid |
| result | output | ROWS*ACC_W | One accumulator per row |

## Verification
A corrupted accumulator or state register shows up at the ports within two cycles of a start. A wrong preload is visible on the result bus during the busy cycle. A wrong sum or a lost sign extension appears when `done` pulses. A state machine that sticks or repeats shows as a `done` pulse that is missing, stretched or extra, or as a result that moves while the block is idle. Extreme operands expose truncated accumulator widths. Changing the weights between the two edges shows whether the wrong edge samples them.

// File: rtl/mv_mac_array.sv
module mv_mac_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int BW     = 8,
  parameter int BIAS_W = 2*BW,
  localparam int ACC_W = 2*BW + $clog2(COLS) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ROWS*COLS*BW-1:0]   weights,
  input  logic [COLS*BW-1:0]        acts,
  input  logic [ROWS*BIAS_W-1:0]    biases,
  output logic                      busy,
  output logic                      done,
  output logic [ROWS*ACC_W-1:0]     result
);

  typedef enum logic {S_IDLE, S_ACCUM} state_t;
  state_t state;

  logic signed [2*BW-1:0]  prod    [ROWS][COLS];
  logic signed [ACC_W-1:0] row_sum [ROWS];
  logic signed [ACC_W-1:0] acc     [ROWS];

  for (genvar n = 0; n < ROWS; n++) begin : g_row
    for (genvar m = 0; m < COLS; m++) begin : g_pe
      assign prod[n][m] = $signed(weights[(n*COLS+m)*BW +: BW]) * $signed(acts[m*BW +: BW]);
    end

    always_comb begin
      row_sum[n] = '0;
      for (int m = 0; m < COLS; m++)
        row_sum[n] = row_sum[n] + ACC_W'(prod[n][m]);
    end

    assign result[n*ACC_W +: ACC_W] = acc[n];
  end

  assign busy = (state == S_ACCUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      for (int n = 0; n < ROWS; n++) acc[n] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          for (int n = 0; n < ROWS; n++)
            acc[n] <= ACC_W'($signed(biases[n*BIAS_W +: BIAS_W]));
          state <= S_ACCUM;
        end
        S_ACCUM: begin
          for (int n = 0; n < ROWS; n++)
            acc[n] <= acc[n] + row_sum[n];
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mv_mac_array_chk.sv
module mv_mac_array_chk #(
  parameter int ROWS  = 4,
  parameter int ACC_W = 19
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [ROWS*ACC_W-1:0] result
);

  assert_start_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  assert_start_while_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !busy);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

bind mv_mac_array mv_mac_array_chk #(.ROWS(ROWS), .ACC_W(ACC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/test_mv_mac_array.sv
module test_mv_mac_array;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int BW     = 8;
  localparam int BIAS_W = 2*BW;
  localparam int ACC_W  = 2*BW + $clog2(COLS) + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [ROWS*COLS*BW-1:0] weights = '0;
  logic [COLS*BW-1:0]      acts = '0;
  logic [ROWS*BIAS_W-1:0]  biases = '0;
  logic busy, done;
  logic [ROWS*ACC_W-1:0]   result;

  int errors = 0, checks = 0;
  int w [ROWS][COLS];
  int x [COLS];
  int b [ROWS];
  logic [ROWS*ACC_W-1:0] held;

  mv_mac_array #(.ROWS(ROWS), .COLS(COLS), .BW(BW), .BIAS_W(BIAS_W)) i_mv_mac_array (
    .clk(clk), .rst_n(rst_n), .start(start), .weights(weights), .acts(acts),
    .biases(biases), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane(input int n);
    return longint'($signed(result[n*ACC_W +: ACC_W]));
  endfunction

  function automatic longint expect_row(input int n);
    longint s = b[n];
    for (int m = 0; m < COLS; m++) s += longint'(w[n][m]) * longint'(x[m]);
    return s;
  endfunction

  task automatic pack_wx();
    for (int n = 0; n < ROWS; n++)
      for (int m = 0; m < COLS; m++) weights[(n*COLS+m)*BW +: BW] = BW'(w[n][m]);
    for (int m = 0; m < COLS; m++) acts[m*BW +: BW] = BW'(x[m]);
  endtask

  task automatic pack_garbage();
    for (int i = 0; i < ROWS*COLS; i++) weights[i*BW +: BW] = BW'($urandom);
    for (int m = 0; m < COLS; m++) acts[m*BW +: BW] = BW'($urandom);
  endtask

  // Runs one operation from a negedge; garbage operands at the start edge (R4).
  task automatic run_op(input string req, input bit hold_start);
    for (int n = 0; n < ROWS; n++) biases[n*BIAS_W +: BIAS_W] = BIAS_W'(b[n]);
    pack_garbage();
    start = 1;
    @(negedge clk);
    start = hold_start;
    check({req, " R2 busy"}, busy, 1);
    check({req, " R5 no early done"}, done, 0);
    for (int n = 0; n < ROWS; n++) check({req, " R2 preload"}, lane(n), b[n]);
    pack_wx();
    @(negedge clk);
    start = 0;
    check({req, " R5 done"}, done, 1);
    check({req, " R5 busy low"}, busy, 0);
    for (int n = 0; n < ROWS; n++) check({req, " R3 sum"}, lane(n), expect_row(n));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    for (int n = 0; n < ROWS; n++) check("R1 result", lane(n), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 done after release", done, 0);
    check("R1 result after release", result == '0, 1);
  endtask

  task automatic test_basic();
    for (int n = 0; n < ROWS; n++) begin
      b[n] = n*10 - 15;
      for (int m = 0; m < COLS; m++) w[n][m] = n - m + 1;
    end
    for (int m = 0; m < COLS; m++) x[m] = m*3 - 4;
    run_op("basic", 0);
    @(negedge clk);
    check("R5 single pulse", done, 0);
  endtask

  task automatic test_random();
    for (int t = 0; t < 6; t++) begin
      for (int n = 0; n < ROWS; n++) begin
        b[n] = $urandom_range(65535) - 32768;
        for (int m = 0; m < COLS; m++) w[n][m] = $urandom_range(255) - 128;
      end
      for (int m = 0; m < COLS; m++) x[m] = $urandom_range(255) - 128;
      run_op("R4 random", 0);
      @(negedge clk);
    end
  endtask

  task automatic test_extremes();
    for (int n = 0; n < ROWS; n++) begin
      b[n] = 32767;
      for (int m = 0; m < COLS; m++) w[n][m] = -128;
    end
    for (int m = 0; m < COLS; m++) x[m] = -128;
    run_op("R8 max", 0);
    @(negedge clk);
    for (int n = 0; n < ROWS; n++) begin
      b[n] = -32768;
      for (int m = 0; m < COLS; m++) w[n][m] = 127;
    end
    run_op("R8 min", 0);
    @(negedge clk);
  endtask

  task automatic test_back_to_back();
    for (int n = 0; n < ROWS; n++) begin
      b[n] = 100 + n;
      for (int m = 0; m < COLS; m++) w[n][m] = 2;
    end
    for (int m = 0; m < COLS; m++) x[m] = m;
    run_op("b2b first", 0);
    for (int n = 0; n < ROWS; n++) b[n] = -7 * n;
    run_op("R2 b2b second", 0);
    @(negedge clk);
  endtask

  task automatic test_start_busy();
    for (int n = 0; n < ROWS; n++) begin
      b[n] = 5;
      for (int m = 0; m < COLS; m++) w[n][m] = 1;
    end
    for (int m = 0; m < COLS; m++) x[m] = 1;
    run_op("R7 start held", 1);
    held = result;
    @(negedge clk);
    check("R7 no new op", busy, 0);
    check("R7 no done", done, 0);
    check("R7 result kept", result == held, 1);
  endtask

  task automatic test_hold();
    held = result;
    for (int k = 0; k < 5; k++) begin
      pack_garbage();
      biases = ROWS*BIAS_W'($urandom);
      @(negedge clk);
      check("R6 hold", result == held, 1);
    end
  endtask

  initial begin
    test_reset();
    test_basic();
    test_random();
    test_extremes();
    test_back_to_back();
    test_start_busy();
    test_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule